// File: doc/BRIEF.md
# Barrel Shifter with Carry and Extend Flags

A purely combinational shifter for a word-wide datapath. It handles logical left, logical right and arithmetic right shifts. Along with the shifted word it produces a carry flag, an extend flag and sign and zero indications. The count arrives on a field that may be wider than needed, and only its low bits are used. The block therefore sees counts from zero up to twice the word width minus one, and gives each range a defined result and carry.

A zero count passes the word through and keeps the caller's previous carry. Counts between one and the word width minus one report the last bit shifted out. A count equal to the word width and a count above it each follow their own fixed rule.

Top module: `shift_cx`

## Requirements
- R1: Only the low log2(WIDTH)+1 bits of `amount` are used (6 bits at WIDTH=32), so a count is taken modulo 64. For example 8'h41 acts as 1, 8'hC0 acts as 0 and 8'h60 acts as 32.
- R2: With a count of zero, `result` equals `din` and `flag_c` equals `carry_in`, for every shift type.
- R3: For counts 1 to 31, `result` is the shifted word. `flag_c` is the last bit shifted out: bit (32 - count) of `din` for a left shift and bit (count - 1) for a right shift.
- R4: A logical shift by exactly 32 gives `result` = 0. `flag_c` is `din` bit 0 for a left shift and `din` bit 31 for a right shift.
- R5: A logical shift by 33 to 63 gives `result` = 0 and `flag_c` = 0.
- R6: An arithmetic right shift by 32 to 63 fills `result` with `din` bit 31 and sets `flag_c` to `din` bit 31.
- R7: `flag_x` always equals `flag_c`.
- R8: `flag_n` is `result` bit 31. `flag_z` is 1 exactly when `result` is zero. `flag_v` is always 0.
- R9: `kind` is encoded as 2'b00 logical left, 2'b01 logical right and 2'b10 arithmetic right. The value 2'b11 is reserved: `result` equals `din` and `flag_c` equals `carry_in`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| din | input | WIDTH | Word to shift |
| amount | input | AMT_W | Shift count; only the low log2(WIDTH)+1 bits are used |
| kind | input | 2 | Shift type (00 left, 01 logical right, 10 arithmetic right, 11 reserved) |
| carry_in | input | 1 | Previous carry, kept on a zero count |
| result | output | WIDTH | Shifted word |
| flag_c | output | 1 | Carry: last bit shifted out |
| flag_x | output | 1 | Extend, equal to carry |
| flag_n | output | 1 | Sign of result |
| flag_z | output | 1 | Result is zero |
| flag_v | output | 1 | Overflow, always 0 |

## Verification
The bench builds the block with its defaults, WIDTH=32 and AMT_W=8. The 32-bit word puts the exact-width count and the counts above it inside the 6-bit count range. The two spare count bits let the bench drive counts of 64 and above, which must wrap. With that count width, a sweep of one-hot words across every count from 1 to 31 shows that the carry picks the correct bit in both directions.

// File: rtl/shift_cx.sv
module shift_cx #(
  parameter int WIDTH = 32,
  parameter int AMT_W = 8
) (
  input  logic [WIDTH-1:0] din,
  input  logic [AMT_W-1:0] amount,
  input  logic [1:0]       kind,
  input  logic             carry_in,
  output logic [WIDTH-1:0] result,
  output logic             flag_c,
  output logic             flag_x,
  output logic             flag_n,
  output logic             flag_z,
  output logic             flag_v
);
  localparam int SH_W = $clog2(WIDTH) + 1;
  localparam logic [1:0] K_LSL = 2'b00;
  localparam logic [1:0] K_LSR = 2'b01;
  localparam logic [1:0] K_ASR = 2'b10;

  logic [SH_W-1:0]  sh;
  logic [WIDTH-1:0] r_res;
  logic [WIDTH-1:0] tap;
  logic             r_c;
  int               n;

  assign sh = amount[SH_W-1:0];

  always_comb begin
    n     = int'(sh);
    r_res = din;
    r_c   = carry_in;
    tap   = '0;
    if (n != 0) begin
      case (kind)
        K_LSL: begin
          if (n < WIDTH) begin
            r_res = din << n;
            tap   = din >> (WIDTH - n);
            r_c   = tap[0];
          end else begin
            r_res = '0;
            r_c   = (n == WIDTH) ? din[0] : 1'b0;
          end
        end
        K_LSR: begin
          if (n < WIDTH) begin
            r_res = din >> n;
            tap   = din >> (n - 1);
            r_c   = tap[0];
          end else begin
            r_res = '0;
            r_c   = (n == WIDTH) ? din[WIDTH-1] : 1'b0;
          end
        end
        K_ASR: begin
          if (n < WIDTH) begin
            r_res = $signed(din) >>> n;
            tap   = din >> (n - 1);
            r_c   = tap[0];
          end else begin
            r_res = {WIDTH{din[WIDTH-1]}};
            r_c   = din[WIDTH-1];
          end
        end
        default: ;
      endcase
    end

    assert_zero_count_R2: assert (n != 0 || (r_res == din && r_c == carry_in));
    assert_reserved_R9: assert (kind != 2'b11 || (r_res == din && r_c == carry_in));
    assert_logic_wide_R5: assert (!((kind == K_LSL || kind == K_LSR) && n > WIDTH) || (r_res == '0 && !r_c));
    assert_logic_exact_R4: assert (!((kind == K_LSL || kind == K_LSR) && n == WIDTH) || r_res == '0);
    assert_asr_fill_R6: assert (!(kind == K_ASR && n >= WIDTH)
                                || ((r_res == '0 || r_res == '1) && r_c == din[WIDTH-1]));
  end

  assign result = r_res;
  assign flag_c = r_c;
  assign flag_x = r_c;
  assign flag_n = r_res[WIDTH-1];
  assign flag_z = (r_res == '0);
  assign flag_v = 1'b0;
endmodule

// File: tb/shift_cx_bench.sv
module shift_cx_bench;
  typedef struct packed {
    logic [1:0]  kind;
    logic [7:0]  amt;
    logic        cin;
    logic [31:0] din;
    logic [31:0] res;
    logic        c;
  } vec_t;

  localparam int NV = 20;
  localparam vec_t VEC [NV] = '{
    '{2'b00, 8'd1,  1'b0, 32'h80000001, 32'h00000002, 1'b1},  // R3
    '{2'b00, 8'd4,  1'b0, 32'h0000000F, 32'h000000F0, 1'b0},  // R3
    '{2'b01, 8'd4,  1'b0, 32'h0000000F, 32'h00000000, 1'b1},  // R3
    '{2'b01, 8'd31, 1'b1, 32'h80000000, 32'h00000001, 1'b0},  // R3
    '{2'b10, 8'd4,  1'b0, 32'h80000000, 32'hF8000000, 1'b0},  // R3
    '{2'b10, 8'd5,  1'b0, 32'h7FFFFFF0, 32'h03FFFFFF, 1'b1},  // R3
    '{2'b00, 8'd32, 1'b0, 32'h00000001, 32'h00000000, 1'b1},  // R4
    '{2'b01, 8'd32, 1'b0, 32'h80000000, 32'h00000000, 1'b1},  // R4
    '{2'b00, 8'd33, 1'b1, 32'hFFFFFFFF, 32'h00000000, 1'b0},  // R5
    '{2'b01, 8'd63, 1'b1, 32'hFFFFFFFF, 32'h00000000, 1'b0},  // R5
    '{2'b10, 8'd32, 1'b0, 32'h80000000, 32'hFFFFFFFF, 1'b1},  // R6
    '{2'b10, 8'd50, 1'b1, 32'h7FFFFFFF, 32'h00000000, 1'b0},  // R6
    '{2'b00, 8'd0,  1'b1, 32'h12345678, 32'h12345678, 1'b1},  // R2
    '{2'b10, 8'd0,  1'b0, 32'h80000000, 32'h80000000, 1'b0},  // R2
    '{2'b00, 8'h41, 1'b0, 32'h40000000, 32'h80000000, 1'b0},  // R1
    '{2'b01, 8'hC0, 1'b1, 32'hABCD0000, 32'hABCD0000, 1'b1},  // R1
    '{2'b00, 8'h60, 1'b0, 32'h00000003, 32'h00000000, 1'b1},  // R1
    '{2'b11, 8'd5,  1'b1, 32'h00000055, 32'h00000055, 1'b1},  // R9
    '{2'b11, 8'd40, 1'b0, 32'hC0000000, 32'hC0000000, 1'b0},  // R9
    '{2'b00, 8'd31, 1'b1, 32'h00000001, 32'h80000000, 1'b0}   // R3
  };

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic [31:0] din;
  logic [7:0]  amount;
  logic [1:0]  kind;
  logic        carry_in;
  logic [31:0] result;
  logic        flag_c, flag_x, flag_n, flag_z, flag_v;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 1'b0;

  shift_cx u_shift_cx (
    .din(din), .amount(amount), .kind(kind), .carry_in(carry_in),
    .result(result), .flag_c(flag_c), .flag_x(flag_x),
    .flag_n(flag_n), .flag_z(flag_z), .flag_v(flag_v)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] k, input logic [7:0] a, input logic ci, input logic [31:0] d);
    @(negedge clk);
    kind = k; amount = a; carry_in = ci; din = d;
    #1;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000 && !done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=done", cycles);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    din = '0; amount = '0; kind = 2'b00; carry_in = 1'b0;
    apply(2'b00, 8'd0, 1'b0, 32'h0);
    check(result == 32'h0 && flag_z && !flag_c, "R2 idle", {result[31:1], flag_c}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      apply(VEC[i].kind, VEC[i].amt, VEC[i].cin, VEC[i].din);
      check(result == VEC[i].res, $sformatf("R3 vector %0d result", i), result, VEC[i].res);
      check(flag_c == VEC[i].c, $sformatf("R4 R5 R6 vector %0d carry", i), {31'd0, flag_c}, {31'd0, VEC[i].c});
      check(flag_x == VEC[i].c, $sformatf("R7 vector %0d extend", i), {31'd0, flag_x}, {31'd0, VEC[i].c});
      check(flag_n == VEC[i].res[31] && flag_z == (VEC[i].res == 32'h0) && !flag_v,
            $sformatf("R8 vector %0d nzv", i), {29'd0, flag_n, flag_z, flag_v},
            {29'd0, VEC[i].res[31], VEC[i].res == 32'h0, 1'b0});
    end

    for (int k = 0; k < 32; k++) begin
      for (int s = 1; s < 32; s++) begin
        apply(2'b01, 8'(s), 1'b0, 32'h1 << k);
        check(flag_c == (k == s - 1), "R3 sweep right carry", {31'd0, flag_c}, {31'd0, k == s - 1});
        apply(2'b00, 8'(s), 1'b0, 32'h1 << k);
        check(flag_c == (k == 32 - s), "R3 sweep left carry", {31'd0, flag_c}, {31'd0, k == 32 - s});
      end
    end

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule